// File: doc/BRIEF.md
# Counter-Based Replacement Age Tracker

This block keeps the replacement bookkeeping for one fully associative group of cache lines, five by default. Each line has a valid flag and a small age counter. On every access the surrounding cache controller reports whether the lookup hit and, on a hit, which line matched. On a miss, the block names the line to fill in the same cycle. At the next clock edge it updates every counter so that the ages stay consistent. Tag compare, data arrays and refill traffic live outside this block.

A mode input chooses between two aging policies that share the same counters. In recency mode a hit makes the hit line the youngest. Only the lines that were younger than it age by one. In arrival-order mode hits change nothing, and the ages only move when a new line is brought in. A line that fills a free slot starts at age zero. A line that replaces a victim in a full group starts at age one in recency mode and at age zero in arrival-order mode. Counters saturate at their largest value and never wrap.

Top module: `age_tracker`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, every valid flag and every age counter is cleared. The first cycle after reset shows `line_valid` = 0 and `line_age` = 0.
- R2: On a miss (`acc_vld`=1, `acc_hit`=0) while at least one line is invalid, `victim_line` equals the lowest-numbered invalid line. After the next edge that line is valid with age 0, in either mode.
- R3: On such a free-slot miss, every other valid line's age rises by one and invalid lines keep age 0.
- R4: In recency mode (`fifo_mode`=0) a hit on line h sets h's age to 0. Each valid line whose age was strictly below h's old age rises by one, and all other ages are unchanged.
- R5: In recency mode, a miss with every line valid names as victim the line with the largest age, the lowest index on a tie. After the next edge the victim has age 1 and every other line's age has risen by one.
- R6: In arrival-order mode (`fifo_mode`=1) a hit leaves every age and valid flag unchanged.
- R7: In arrival-order mode, a miss with every line valid names the largest-age line as victim, the lowest index on a tie. After the next edge the victim has age 0 and every other line has risen by one.
- R8: `victim_line` is combinational from the current state in the cycle `acc_vld` is high. State changes only at the following edge, and a cycle with `acc_vld`=0 changes nothing, whatever the other inputs are.
- R9: Ages are CW = clog2(N)+1 bits wide, so 4 bits for N=5. Line i's age sits at `line_age[i*CW +: CW]` and its valid flag at `line_valid[i]`.
- R10: In recency mode on five lines, ages 2,3,4,1,0 (lines 0..4) followed by a hit on line 1 give 3,0,4,2,1. A miss after that names line 2 and gives 4,1,1,3,2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_vld | input | 1 | An access is reported this cycle |
| acc_hit | input | 1 | 1 = lookup hit, 0 = miss |
| hit_line | input | IW | Index of the matching line on a hit |
| fifo_mode | input | 1 | 0 = recency aging, 1 = arrival-order aging |
| victim_line | output | IW | Line to fill on a miss, valid in the same cycle |
| line_valid | output | N | Valid flag per line |
| line_age | output | N*CW | Packed age counters, line i at bits i*CW +: CW |

## Verification
The assertions assume that a reported hit names a line below N that is currently valid, since a hit on an empty or out-of-range slot has no meaning for the policy. The random stimulus draws its hit index only from lines that its own model holds as valid, and it reports a miss whenever no line is valid yet. Mode changes, idle cycles with noise on the other inputs, and long miss runs in both modes are mixed in. Directed sequences reproduce the five-line worked example and the fill order from reset.

// File: rtl/age_pkg.sv
// Package: shared definitions for the replacement age tracker.
// Assumes: nothing beyond IEEE 1800-2017 semantics.
package age_pkg;

    // Aging policy selected by the mode input.
    typedef enum logic {
        AGE_RECENCY = 1'b0,
        AGE_ARRIVAL = 1'b1
    } age_mode_e;

    // Width of a line index for a group of n lines (at least one bit).
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Width of an age counter for a group of n lines.
    function automatic int age_width(input int n);
        return ((n > 1) ? $clog2(n) : 1) + 1;
    endfunction

endpackage

// File: rtl/age_victim_pick.sv
// Module: age_victim_pick
// Chooses the line to fill on a miss: the lowest-numbered invalid line if
// any exists, otherwise the line with the largest age (lowest index wins a
// tie). Purely combinational.
// Assumes: ages of invalid lines are zero (kept so by age_line_cell).
module age_victim_pick #(
    parameter int N  = 5,
    parameter int IW = 3,
    parameter int CW = 4
) (
    input  logic [N-1:0][CW-1:0] ages,
    input  logic [N-1:0]         valid,
    output logic [IW-1:0]        victim,
    output logic                 full_set
);

    logic          free_found;
    logic [IW-1:0] free_idx;
    logic [IW-1:0] best_idx;
    logic [CW-1:0] best_age;

    // Find the lowest-numbered free line.
    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (!valid[i] && !free_found) begin
                free_found = 1'b1;
                free_idx   = IW'(i);
            end
        end
    end

    // Find the oldest line; strict compare keeps the lowest index on ties.
    always_comb begin
        best_idx = '0;
        best_age = ages[0];
        for (int i = 1; i < N; i++) begin
            if (ages[i] > best_age) begin
                best_age = ages[i];
                best_idx = IW'(i);
            end
        end
    end

    // Free slot takes precedence over eviction.
    always_comb begin
        full_set = !free_found;
        victim   = free_found ? free_idx : best_idx;
    end

endmodule

// File: rtl/age_line_cell.sv
// Module: age_line_cell
// Holds the valid flag and saturating age counter of one line and applies
// the hit/miss update rule of the selected policy at each reported access.
// Assumes: on a hit, hit_age is the current age of the hit line, and that
// line is valid; sel_victim is high for exactly one cell on a miss.
module age_line_cell #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_en,
    input  logic          is_hit,
    input  logic          arrival,
    input  logic          sel_hit,
    input  logic          sel_victim,
    input  logic          full_set,
    input  logic [CW-1:0] hit_age,
    output logic [CW-1:0] age_q,
    output logic          valid_q
);

    localparam logic [CW-1:0] AGE_MAX = {CW{1'b1}};

    logic [CW-1:0] age_d;
    logic [CW-1:0] age_inc;
    logic          valid_d;

    // Saturating increment of this line's age.
    always_comb begin
        age_inc = (age_q == AGE_MAX) ? age_q : age_q + CW'(1);
    end

    // Next-state rule for one line.
    always_comb begin
        age_d   = age_q;
        valid_d = valid_q;
        if (upd_en) begin
            if (is_hit) begin
                if (!arrival) begin
                    if (sel_hit) begin
                        age_d = '0;
                    end else if (valid_q && (age_q < hit_age)) begin
                        age_d = age_inc;
                    end
                end
            end else begin
                if (sel_victim) begin
                    valid_d = 1'b1;
                    age_d   = (full_set && !arrival) ? CW'(1) : '0;
                end else if (valid_q) begin
                    age_d = age_inc;
                end
            end
        end
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            age_q   <= age_d;
            valid_q <= valid_d;
        end
    end

    // R1: the cycle after reset the line is empty and young.
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (age_q == '0) && !valid_q);

    // R8: no access, no change.
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(age_q) && $stable(valid_q));

    // R6: arrival-order hits never move an age.
    assert_arrival_hit_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && is_hit && arrival) |=> $stable(age_q) && $stable(valid_q));

    // R4: a recency hit makes this line youngest.
    assert_recency_hit_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && is_hit && !arrival && sel_hit) |=> (age_q == '0));

    // R2: a line chosen from the free pool becomes valid at age zero.
    assert_free_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !is_hit && sel_victim && !full_set) |=> valid_q && (age_q == '0));

    // R5: in recency mode a replaced line starts at one.
    assert_recency_replace_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !is_hit && sel_victim && full_set && !arrival) |=> (age_q == CW'(1)));

    // R7: in arrival-order mode a replaced line starts at zero.
    assert_arrival_replace_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !is_hit && sel_victim && full_set && arrival) |=> (age_q == '0));

    // R3: an invalid line not being filled stays invalid.
    assert_invalid_stays_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_q && !(upd_en && !is_hit && sel_victim)) |=> !valid_q);

endmodule

// File: rtl/age_tracker.sv
// Module: age_tracker (top)
// Replacement age tracker for one fully associative group of N lines.
// Reports the victim line combinationally on a miss and updates all ages
// at the next clock edge, in recency or arrival-order mode.
// Assumes: a reported hit names a valid line with index below N.
module age_tracker
    import age_pkg::*;
#(
    parameter int  N  = 5,
    localparam int IW = idx_width(N),
    localparam int CW = age_width(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_vld,
    input  logic            acc_hit,
    input  logic [IW-1:0]   hit_line,
    input  logic            fifo_mode,
    output logic [IW-1:0]   victim_line,
    output logic [N-1:0]    line_valid,
    output logic [N*CW-1:0] line_age
);

    age_mode_e           mode;
    logic                arrival;
    logic [N-1:0][CW-1:0] ages;
    logic [N-1:0]        valid;
    logic [CW-1:0]       hit_age;
    logic                full_set;

    // Decode the policy selection.
    always_comb begin
        mode    = age_mode_e'(fifo_mode);
        arrival = (mode == AGE_ARRIVAL);
    end

    // Age of the line named by the hit index (zero if out of range).
    always_comb begin
        hit_age = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_line == IW'(i)) hit_age = ages[i];
        end
    end

    age_victim_pick #(.N(N), .IW(IW), .CW(CW)) pick_i (
        .ages     (ages),
        .valid    (valid),
        .victim   (victim_line),
        .full_set (full_set)
    );

    for (genvar g = 0; g < N; g++) begin : g_line
        age_line_cell #(.CW(CW)) cell_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .upd_en     (acc_vld),
            .is_hit     (acc_hit),
            .arrival    (arrival),
            .sel_hit    (hit_line == IW'(g)),
            .sel_victim (victim_line == IW'(g)),
            .full_set   (full_set),
            .hit_age    (hit_age),
            .age_q      (ages[g]),
            .valid_q    (valid[g])
        );
    end

    // Flatten per-line state onto the output ports.
    always_comb begin
        line_valid = valid;
        line_age   = ages;
    end

    // R2: with a free slot available, the victim is never a valid line.
    assert_victim_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && !acc_hit && (line_valid != {N{1'b1}})) |-> !line_valid[victim_line]);

    // R8: the victim index always names an existing line.
    assert_victim_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_vld |-> (int'(victim_line) < N));

endmodule

// File: tb/age_tracker_tb_top.sv
`timescale 1ns/1ps
module age_tracker_tb_top;

    localparam int N  = 5;
    localparam int IW = 3;
    localparam int CW = 4;
    localparam int AMAX = 15;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            acc_vld, acc_hit, fifo_mode;
    logic [IW-1:0]   hit_line;
    logic [IW-1:0]   victim_line;
    logic [N-1:0]    line_valid;
    logic [N*CW-1:0] line_age;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 0;
    int  m_age [N];
    bit  m_val [N];

    always #10 clk = ~clk;

    age_tracker #(.N(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_hit(acc_hit),
        .hit_line(hit_line), .fifo_mode(fifo_mode), .victim_line(victim_line),
        .line_valid(line_valid), .line_age(line_age)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit m_full();
        for (int j = 0; j < N; j++) if (!m_val[j]) return 0;
        return 1;
    endfunction

    function automatic int m_victim();
        int b;
        for (int j = 0; j < N; j++) if (!m_val[j]) return j;
        b = 0;
        for (int j = 1; j < N; j++) if (m_age[j] > m_age[b]) b = j;
        return b;
    endfunction

    function automatic int sat(input int a);
        return (a >= AMAX) ? AMAX : a + 1;
    endfunction

    task automatic m_apply(input bit hit, input int idx, input bit fifo);
        int h, v; bit f;
        f = m_full();
        if (hit) begin
            if (!fifo) begin
                h = m_age[idx];
                for (int j = 0; j < N; j++)
                    if (j == idx) m_age[j] = 0;
                    else if (m_val[j] && m_age[j] < h) m_age[j] = sat(m_age[j]);
            end
        end else begin
            v = m_victim();
            for (int j = 0; j < N; j++)
                if (j == v) begin m_val[j] = 1; m_age[j] = (f && !fifo) ? 1 : 0; end
                else if (m_val[j]) m_age[j] = sat(m_age[j]);
        end
    endtask

    // Compare every line's age and valid flag (R9 field layout).
    task automatic cmp_state(input string req);
        for (int j = 0; j < N; j++) begin
            check(req, $sformatf("R9 age line %0d", j), int'(line_age[j*CW +: CW]), m_age[j]);
            check(req, $sformatf("R9 valid line %0d", j), int'(line_valid[j]), int'(m_val[j]));
        end
    endtask

    task automatic access(input bit hit, input int idx, input bit fifo, input string tag);
        string vt, st; bit f;
        f = m_full();
        vt = f ? (fifo ? "R7" : "R5") : "R2";
        st = hit ? (fifo ? "R6" : "R4") : (f ? (fifo ? "R7" : "R5") : "R3");
        if (tag != "") begin vt = tag; st = tag; end
        @(negedge clk);
        acc_vld = 1; acc_hit = hit; hit_line = IW'(idx); fifo_mode = fifo;
        #2;
        if (!hit) check(vt, "victim same cycle", int'(victim_line), m_victim());
        cmp_state("R8");              // nothing moves before the edge
        m_apply(hit, idx, fifo);
        @(negedge clk);
        acc_vld = 0;
        cmp_state(st);
    endtask

    task automatic idle_noise(input int cycles);
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            acc_vld = 0; acc_hit = 1'($urandom); fifo_mode = 1'($urandom);
            hit_line = IW'($urandom_range(0, N-1));
        end
        @(negedge clk);
        cmp_state("R8");
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0; acc_vld = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
        for (int j = 0; j < N; j++) begin m_age[j] = 0; m_val[j] = 0; end
        @(negedge clk);
        check("R1", "valid flags after reset", int'(line_valid), 0);
        check("R1", "ages after reset", int'(line_age), 0);
    endtask

    initial begin
        void'($urandom(32'h1A2B3C4D));
        rst_n = 0; acc_vld = 0; acc_hit = 0; hit_line = '0; fifo_mode = 0;
        do_reset();

        // R10: fill from reset, then reorder recency to 2,3,4,1,0.
        for (int k = 0; k < N; k++) access(0, 0, 0, "");
        access(1, 2, 0, ""); access(1, 1, 0, ""); access(1, 0, 0, "");
        access(1, 3, 0, ""); access(1, 4, 0, "");
        check("R10", "start age line 0", m_age[0], 2);
        check("R10", "start age line 2", m_age[2], 4);
        access(1, 1, 0, "R10");
        check("R10", "age line 0 after hit", int'(line_age[0 +: CW]), 3);
        check("R10", "age line 1 after hit", int'(line_age[CW +: CW]), 0);
        access(0, 0, 0, "R10");
        check("R10", "age line 2 after miss", int'(line_age[2*CW +: CW]), 1);
        check("R10", "age line 3 after miss", int'(line_age[3*CW +: CW]), 3);

        // R6 and R7: arrival-order hits and replacements.
        access(1, 3, 1, ""); access(1, 0, 1, "");
        for (int k = 0; k < 6; k++) access(0, 0, 1, "");
        idle_noise(4);

        // R2/R3 in arrival-order mode from a fresh reset.
        do_reset();
        access(0, 0, 1, ""); access(0, 0, 1, ""); access(1, 0, 1, "");
        access(0, 0, 0, "");

        // Constrained random mix.
        for (int n = 0; n < 3000; n++) begin
            int r, idx; bit any, fifo, hit;
            any = 0;
            for (int j = 0; j < N; j++) if (m_val[j]) any = 1;
            r = $urandom_range(0, 99);
            fifo = ($urandom_range(0, 99) < 35);
            if (r < 10) begin
                idle_noise(1);
            end else if (r < 12) begin
                do_reset();
            end else begin
                hit = any && ($urandom_range(0, 99) < 55);
                idx = 0;
                if (hit) begin
                    idx = $urandom_range(0, N-1);
                    while (!m_val[idx]) idx = $urandom_range(0, N-1);
                end
                access(hit, idx, fifo, "");
            end
        end

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(20ns * 190000);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule